// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Four-Times Oversampled Receiver

This block is a small serial port that a processor reaches through a 16-word register window. It sends and receives asynchronous 8N1 characters: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line rests high between characters. There is no FIFO, no parity and no flow control. Each direction holds exactly one byte.

A single divider parameter, `DIVISOR`, sets the timing. The system clock divided by `DIVISOR` gives the receiver's sampling tick. The transmitter's bit clock is that tick divided by four. The baud rate is therefore clk / (4 × `DIVISOR`). A 4.9152 MHz clock with the default of 128 gives 9600 baud. For 25 MHz and 115200 baud the value is about 54.

The receiver looks at the line only four times per bit. It recognises a start edge and checks the line again two ticks later, near the middle of the start bit. It then takes one sample every four ticks. Every bus request is answered with a one-cycle acknowledge one clock later, so the host never waits on this port.

Top module: `uart4x_port`

## Requirements
- R1: After reset, `txd` is high and `ack` is low. The status register (offset 0) reads 0x02: transmit-empty set, all other flags clear.
- R2: A request is acknowledged by `ack` high for exactly one cycle, in the clock after the request is sampled. Read data is valid while `ack` is high.
- R3: The sampling tick repeats every `DIVISOR` clocks. Every transmitted bit lasts exactly 4 × `DIVISOR` clocks.
- R4: A write to the data register (offset 1) while transmit-empty is set sends an 8N1 frame of `wdata`, LSB first. Transmit-empty, status bit 1, reads 0 from the write until the frame ends.
- R5: A write to the data register while transmit-empty is clear is ignored. It does not change the frame in flight, and no further frame follows.
- R6: A correctly framed incoming character sets receive-ready (status bit 0). Reading the data register then returns it in bits 7:0.
- R7: A low pulse on `rxd` that has ended by the mid-start-bit check is rejected, and receive-ready stays clear.
- R8: A character whose stop bit is low is still delivered, but it sets framing-error (status bit 2). The receiver then waits for the line to return high before it looks for a new start bit.
- R9: A character that completes while receive-ready is already set sets overrun (status bit 3). The data register then holds the newest character.
- R10: A read of the data register clears receive-ready, framing-error and overrun.
- R11: Offsets 2 to 15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Bus access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word offset inside the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `ack` |
| ack | output | 1 | One-cycle access acknowledge |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The hardest cases to reach from the ports are those that depend on where a line event falls relative to the free-running sampling tick. These are a start glitch that must be seen once and then rejected at the mid-bit check, and a write that lands while a frame is in flight. The bench runs with a divider of 4, so one bit lasts 16 clocks. A low pulse of five clocks is always caught by one tick and is always gone by the confirming tick two ticks later. The bench times the second write from the observed start edge, so it falls inside the frame. A loopback sweep sends all 256 byte values through both directions.

// File: rtl/uart4x_pkg.sv
package uart4x_pkg;
    localparam int BYTE_W   = 8;
    localparam int OVERSAMP = 4;

    localparam logic [3:0] OFS_STATUS = 4'd0;
    localparam logic [3:0] OFS_DATA   = 4'd1;

    localparam int ST_RX_READY = 0;
    localparam int ST_TX_EMPTY = 1;
    localparam int ST_FRAME    = 2;
    localparam int ST_OVERRUN  = 3;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;
endpackage

// File: rtl/uart4x_tick.sv
module uart4x_tick #(
    parameter int DIVISOR = 128
) (
    input  logic clk,
    input  logic rst,
    output logic samp_tick,
    output logic bit_tick
);
    localparam int CW = (DIVISOR > 2) ? $clog2(DIVISOR) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIVISOR - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    qtr;
        logic          samp;
        logic          bitt;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d      = q;
        d.samp = 1'b0;
        d.bitt = 1'b0;
        if (q.cnt == LAST) begin
            d.cnt  = '0;
            d.samp = 1'b1;
            d.qtr  = q.qtr + 2'd1;
            d.bitt = (q.qtr == 2'd3);
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign samp_tick = q.samp;
    assign bit_tick  = q.bitt;

    AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst) bit_tick |-> samp_tick); // R3
    AST_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (rst) samp_tick |=> !samp_tick); // R3
endmodule

// File: rtl/uart4x_tx.sv
module uart4x_tx
    import uart4x_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              txd,
    output logic              empty
);
    typedef struct packed {
        tx_state_e         state;
        logic [BYTE_W-1:0] shreg;
        logic [2:0]        idx;
        logic              pend;
        logic              line;
    } tx_t;

    tx_t q, d;

    assign empty = !q.pend && (q.state == TX_IDLE);
    assign txd   = q.line;

    always_comb begin
        d = q;
        if (load && empty) begin
            d.pend  = 1'b1;
            d.shreg = load_data;
        end
        if (bit_tick) begin
            case (q.state)
                TX_IDLE: begin
                    if (d.pend) begin
                        d.state = TX_START;
                        d.line  = 1'b0;
                        d.pend  = 1'b0;
                    end
                end
                TX_START: begin
                    d.state = TX_DATA;
                    d.line  = d.shreg[0];
                    d.shreg = {1'b0, d.shreg[BYTE_W-1:1]};
                    d.idx   = '0;
                end
                TX_DATA: begin
                    if (q.idx == 3'd7) begin
                        d.state = TX_STOP;
                        d.line  = 1'b1;
                    end else begin
                        d.line  = q.shreg[0];
                        d.shreg = {1'b0, q.shreg[BYTE_W-1:1]};
                        d.idx   = q.idx + 3'd1;
                    end
                end
                default: begin
                    d.state = TX_IDLE;
                    d.line  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.state <= TX_IDLE;
            q.line  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    AST_TX_ON_BIT_TICK: assert property (@(posedge clk) disable iff (rst) !bit_tick |=> $stable(txd)); // R3
    AST_TX_BUSY_LOAD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (load && !empty && !bit_tick) |=> $stable(q.shreg)); // R5
endmodule

// File: rtl/uart4x_rx.sv
module uart4x_rx
    import uart4x_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              samp_tick,
    input  logic              rxd,
    output logic              done,
    output logic              stop_ok,
    output logic [BYTE_W-1:0] data
);
    typedef struct packed {
        logic              s1;
        logic              s2;
        rx_state_e         state;
        logic [1:0]        cnt;
        logic [2:0]        idx;
        logic [BYTE_W-1:0] shreg;
    } rx_t;

    rx_t  q, d;
    logic line;

    assign line = q.s2;
    assign data = q.shreg;

    always_comb begin
        d       = q;
        d.s1    = rxd;
        d.s2    = q.s1;
        done    = 1'b0;
        stop_ok = 1'b0;
        if (samp_tick) begin
            case (q.state)
                RX_IDLE: begin
                    if (!line) begin
                        d.state = RX_START;
                        d.cnt   = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == 2'd1) begin
                        d.cnt   = '0;
                        d.idx   = '0;
                        d.state = line ? RX_IDLE : RX_DATA;
                    end else begin
                        d.cnt = q.cnt + 2'd1;
                    end
                end
                RX_DATA: begin
                    d.cnt = q.cnt + 2'd1;
                    if (q.cnt == 2'd3) begin
                        d.shreg = {line, q.shreg[BYTE_W-1:1]};
                        if (q.idx == 3'd7) d.state = RX_STOP;
                        else               d.idx   = q.idx + 3'd1;
                    end
                end
                RX_STOP: begin
                    d.cnt = q.cnt + 2'd1;
                    if (q.cnt == 2'd3) begin
                        done    = 1'b1;
                        stop_ok = line;
                        d.state = line ? RX_IDLE : RX_BREAK;
                    end
                end
                default: begin
                    if (line) d.state = RX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
            q.state <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (rst) done |-> samp_tick); // R6
    AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (q.state == RX_BREAK && !line) |=> (q.state == RX_BREAK)); // R8
endmodule

// File: rtl/uart4x_port.sv
module uart4x_port
    import uart4x_pkg::*;
#(
    parameter int DIVISOR = 128,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ack,
    input  logic              rxd,
    output logic              txd
);
    typedef struct packed {
        logic              ack;
        logic [7:0]        rdata;
        logic              rx_ready;
        logic              fe;
        logic              ovr;
        logic [BYTE_W-1:0] rx_byte;
    } regs_t;

    regs_t q, d;

    logic samp_tick, bit_tick;
    logic tx_load, tx_empty;
    logic rx_done, rx_stop_ok;
    logic [BYTE_W-1:0] rx_data;
    logic take, rd_data;

    uart4x_tick #(.DIVISOR(DIVISOR)) u_tick (
        .clk(clk), .rst(rst), .samp_tick(samp_tick), .bit_tick(bit_tick)
    );

    uart4x_tx u_tx (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .load(tx_load),
        .load_data(wdata), .txd(txd), .empty(tx_empty)
    );

    uart4x_rx u_rx (
        .clk(clk), .rst(rst), .samp_tick(samp_tick), .rxd(rxd),
        .done(rx_done), .stop_ok(rx_stop_ok), .data(rx_data)
    );

    assign take    = req && !q.ack;
    assign rd_data = take && !we && (addr == ADDR_W'(OFS_DATA));
    assign tx_load = take && we && (addr == ADDR_W'(OFS_DATA));

    always_comb begin
        d       = q;
        d.ack   = take;
        d.rdata = '0;
        if (take && !we) begin
            if (addr == ADDR_W'(OFS_STATUS)) begin
                d.rdata[ST_RX_READY] = q.rx_ready;
                d.rdata[ST_TX_EMPTY] = tx_empty;
                d.rdata[ST_FRAME]    = q.fe;
                d.rdata[ST_OVERRUN]  = q.ovr;
            end else if (addr == ADDR_W'(OFS_DATA)) begin
                d.rdata = q.rx_byte;
            end
        end
        if (rd_data) begin
            d.rx_ready = 1'b0;
            d.fe       = 1'b0;
            d.ovr      = 1'b0;
        end
        if (rx_done) begin
            d.ovr      = d.ovr | (q.rx_ready && !rd_data);
            d.fe       = d.fe | !rx_stop_ok;
            d.rx_ready = 1'b1;
            d.rx_byte  = rx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign ack   = q.ack;
    assign rdata = q.rdata;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst) ack |=> !ack); // R2
    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst) ack |-> $past(req)); // R2
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst) !ack |-> (rdata == 8'd0)); // R2
    AST_READY_AFTER_RX: assert property (@(posedge clk) disable iff (rst) rx_done |=> q.rx_ready); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_done) |=> (!q.rx_ready && !q.fe && !q.ovr)); // R10
endmodule

// File: tb/uart4x_port_test.sv
module uart4x_port_test;
    localparam int DIV  = 4;
    localparam int BITC = 4 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       we  = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack;
    logic       loop = 1'b1;
    logic       brx  = 1'b1;
    logic       txd;
    logic       rxd;
    int         total = 0;
    int         bad   = 0;
    int         cyc   = 0;

    assign rxd = loop ? txd : brx;

    uart4x_port #(.DIVISOR(DIV), .ADDR_W(4)) uut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack(ack), .rxd(rxd), .txd(txd)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [3:0] a, input logic [7:0] dv, output logic [7:0] r);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = dv;
        @(negedge clk);
        chk("R2 ack high", {31'd0, ack}, 32'd1);
        r   = rdata;
        req = 1'b0; we = 1'b0;
        @(negedge clk);
        chk("R2 ack one cycle", {31'd0, ack}, 32'd0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] r);
        bus(1'b0, a, 8'd0, r);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] dv);
        logic [7:0] dummy;
        bus(1'b1, a, dv, dummy);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stopv);
        brx = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            brx = b[i];
            repeat (BITC) @(negedge clk);
        end
        brx = stopv;
        repeat (BITC) @(negedge clk);
        brx = 1'b1;
        repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic wait_ready(output logic ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int i = 0; i < 200 && !ok; i++) begin
            rd(4'd0, s);
            ok = s[0];
        end
    endtask

    initial begin
        #(8 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic       ok;
        logic       high;
        int         t0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd idle", {31'd0, txd}, 32'd1);
        chk("R1 ack low", {31'd0, ack}, 32'd0);
        rd(4'd0, r);
        chk("R1 status", {24'd0, r}, 32'h02);

        // R11 unused offsets
        wr(4'd5, 8'h55);
        rd(4'd5, r);
        chk("R11 offset 5 reads zero", {24'd0, r}, 32'h00);
        rd(4'd15, r);
        chk("R11 offset 15 reads zero", {24'd0, r}, 32'h00);
        high = 1'b1;
        repeat (3 * BITC) begin
            @(negedge clk);
            high = high & txd;
        end
        chk("R11 write starts nothing", {31'd0, high}, 32'd1);
        rd(4'd0, r);
        chk("R11 status unchanged", {24'd0, r}, 32'h02);

        // R3 R4 R5 transmit waveform of 0xA5
        wr(4'd1, 8'hA5);
        for (int i = 0; i < 40 && txd; i++) @(negedge clk);
        chk("R4 start bit low", {31'd0, txd}, 32'd0);
        t0 = cyc;
        for (int i = 0; i < 40 && !txd; i++) @(negedge clk);
        chk("R3 bit length", cyc - t0, BITC);
        rd(4'd0, r);
        chk("R4 tx_empty low while busy", {31'd0, r[1]}, 32'd0);
        wr(4'd1, 8'h3C);
        for (int k = 1; k <= 9; k++) begin
            wait_until(t0 + BITC / 2 + BITC * k);
            if (k == 9) chk("R4 stop bit", {31'd0, txd}, 32'd1);
            else        chk("R4 R5 data bit", {31'd0, txd}, {31'd0, 1'b0 | (8'hA5 >> (k - 1)) & 8'd1});
        end
        high = 1'b1;
        repeat (3 * BITC) begin
            @(negedge clk);
            high = high & txd;
        end
        chk("R5 no second frame", {31'd0, high}, 32'd1);
        rd(4'd0, r);
        chk("R6 loopback status", {24'd0, r}, 32'h03);
        rd(4'd1, r);
        chk("R6 loopback byte", {24'd0, r}, 32'hA5);
        rd(4'd0, r);
        chk("R10 ready cleared", {24'd0, r}, 32'h02);

        // R4 R6 loopback sweep of all byte values
        for (int v = 0; v < 256; v++) begin
            wr(4'd1, v[7:0]);
            wait_ready(ok);
            chk("R6 sweep ready", {31'd0, ok}, 32'd1);
            rd(4'd1, r);
            chk("R4 R6 sweep byte", {24'd0, r}, v);
        end

        // receiver driven directly
        loop = 1'b0;
        brx  = 1'b1;
        repeat (2 * BITC) @(negedge clk);

        // R7 short start glitch
        brx = 1'b0;
        repeat (5) @(negedge clk);
        brx = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        rd(4'd0, r);
        chk("R7 glitch rejected", {24'd0, r}, 32'h02);

        // R6 direct reception
        send_rx(8'h5A, 1'b1);
        rd(4'd0, r);
        chk("R6 ready set", {24'd0, r}, 32'h03);
        rd(4'd1, r);
        chk("R6 byte", {24'd0, r}, 32'h5A);

        // R8 framing error
        send_rx(8'h81, 1'b0);
        rd(4'd0, r);
        chk("R8 framing flag", {24'd0, r}, 32'h07);
        rd(4'd1, r);
        chk("R8 byte kept", {24'd0, r}, 32'h81);
        rd(4'd0, r);
        chk("R10 flags cleared after fe", {24'd0, r}, 32'h02);

        // R9 overrun
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        rd(4'd0, r);
        chk("R9 overrun flag", {24'd0, r}, 32'h0B);
        rd(4'd1, r);
        chk("R9 newest byte", {24'd0, r}, 32'h22);
        rd(4'd0, r);
        chk("R10 flags cleared after overrun", {24'd0, r}, 32'h02);

        // R8 receiver recovers after break
        send_rx(8'hC3, 1'b1);
        rd(4'd1, r);
        chk("R8 recovery byte", {24'd0, r}, 32'hC3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule